// File: doc/BRIEF.md
# Multi-Cycle Hardwired Instruction Sequencer

This block is the hardwired control unit of a small register-to-register processor. It walks each instruction through a fixed set of phases: fetch, decode, an operand-fetch phase that is entered only when the operand sits in memory, execute, and a closing write-back or store phase. In every cycle it drives a set of control strobes into a datapath that lives outside the block. That datapath holds the program counter, the memory address and data registers, the instruction register, the register file, the ALU, the status register and the memory.

The sequencer reads the opcode field and the addressing-mode bit from the instruction register. It latches the decoded class once per instruction, in the decode cycle. Four classes exist: ALU operations on registers, ALU operations with one operand in memory, LOAD and STORE. A fifth opcode group does nothing and returns straight to fetch.

Base-plus-offset addressing reuses the ALU to form the effective address. Memory reads and writes are held until the memory raises its ready input.

Top module: `seq_core`

## Requirements
- R1: While `rst` is high every control output is 0. In the first cycle after `rst` falls, the sequencer asserts `mar_load` with `mar_sel`=0 (program counter). In every cycle, any output a step does not name is 0.
- R2: Fetch runs in a fixed order. First comes one `mar_load` cycle. Then `mem_read` is held until `mem_ready`; in the ready cycle `mdr_load` is also asserted with `mdr_sel`=0 (memory). Then one cycle asserts `ir_load` and `pc_inc` together. Then one decode cycle follows with all outputs 0.
- R3: Opcodes whose top two bits are 00 are ALU register operations. They go from decode straight to execute, whatever `ir_mode` is, with no memory access.
- R4: A memory-operand class (opcode top bits 01, LOAD 1000 or STORE 1001) with `ir_mode`=0 asserts `mar_load` with `mar_sel`=1 (address field of IR) in the cycle after decode.
- R5: With `ir_mode`=1 (base plus offset), those classes spend the cycle after decode on `mar_load` with `mar_sel`=2 (ALU result), `alu_fn`=0 (add), `alu_a_sel`=0 (register) and `alu_b_sel`=1 (offset).
- R6: For opcodes 00xx and 01xx, execute drives `alu_fn` = {0, opcode[1:0]} and asserts `status_load`. `alu_a_sel` is 1 (MDR) for 01xx and 0 for 00xx.
- R7: After execute, one write-back cycle asserts `rd_load` with the ALU controls unchanged. The next cycle starts a new fetch.
- R8: For LOAD, execute drives `alu_fn`=4 (pass input 1) with `alu_a_sel`=1 and does not assert `status_load`. Write-back then follows as in R7.
- R9: STORE follows its address cycle with one cycle of `mdr_load` and `mdr_sel`=1 (register data). It then holds `mem_write` until `mem_ready` and returns to fetch. It never asserts `status_load` or `rd_load`.
- R10: Opcodes with top bits 11 return from decode directly to fetch.
- R11: At most one of `mar_load`, `mdr_load`, `ir_load`, `status_load` and `rd_load` is high in any cycle. `mem_read` and `mem_write` are never high together.
- R12: An asserted `mem_read` or `mem_write` stays asserted in the following cycle while `mem_ready` is low, for both fetch and operand reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | OPC_W | Opcode field of the instruction register |
| ir_mode | input | 1 | Addressing mode: 0 direct, 1 base plus offset |
| mem_ready | input | 1 | Memory has completed the current read or write |
| mar_load | output | 1 | Load the memory address register |
| mar_sel | output | 2 | MAR source: 0 PC, 1 IR address field, 2 ALU result |
| mdr_load | output | 1 | Load the memory data register |
| mdr_sel | output | 1 | MDR source: 0 memory, 1 register data |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| ir_load | output | 1 | Copy MDR into the instruction register |
| pc_inc | output | 1 | Increment the program counter by one |
| alu_a_sel | output | 1 | ALU input 1: 0 register, 1 MDR |
| alu_b_sel | output | 1 | ALU input 2: 0 register, 1 IR offset |
| alu_fn | output | FN_W | ALU function: 0 add, 1 sub, 2 and, 3 or, 4 pass input 1 |
| status_load | output | 1 | Capture the ALU flags into the status register |
| rd_load | output | 1 | Load the destination register from the result bus |

## Verification
The bench builds the block with its defaults: OPC_W=4, FN_W=3 and a pass code of 4. That is the smallest width that holds the four class groups, the four ALU functions and the separate pass function that LOAD needs. With these values every class, both addressing modes and the do-nothing group can be reached with one opcode each. The bench also varies the number of memory wait cycles. This exercises the zero-wait case, long held reads in fetch and in operand fetch, and held store writes.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        K_ALU_REG,
        K_ALU_MEM,
        K_LOAD,
        K_STORE,
        K_NOP
    } kind_e;

    typedef enum logic [3:0] {
        S_F_ADDR,
        S_F_READ,
        S_F_IR,
        S_DECODE,
        S_EA,
        S_OP_ADDR,
        S_OP_READ,
        S_EXEC,
        S_WB,
        S_ST_DATA,
        S_ST_WRITE
    } state_e;

    localparam logic [1:0] MAR_FROM_PC  = 2'd0;
    localparam logic [1:0] MAR_FROM_IR  = 2'd1;
    localparam logic [1:0] MAR_FROM_ALU = 2'd2;

    typedef struct packed {
        logic       mar_load;
        logic [1:0] mar_sel;
        logic       mdr_load;
        logic       mdr_sel;
        logic       mem_read;
        logic       mem_write;
        logic       ir_load;
        logic       pc_inc;
        logic       alu_a_sel;
        logic       alu_b_sel;
        logic       status_load;
        logic       rd_load;
    } ctrl_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int              OPC_W   = 4,
    parameter int              FN_W    = 3,
    parameter logic [FN_W-1:0] FN_PASS = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output kind_e            kind,
    output logic [FN_W-1:0]  fn
);
    localparam int GRP_HI = OPC_W - 1;

    logic [1:0] grp;
    assign grp = opcode[GRP_HI -: 2];

    always_comb begin
        kind = K_NOP;
        fn   = '0;
        case (grp)
            2'b00: begin
                kind = K_ALU_REG;
                fn   = FN_W'(opcode[1:0]);
            end
            2'b01: begin
                kind = K_ALU_MEM;
                fn   = FN_W'(opcode[1:0]);
            end
            2'b10: begin
                if (opcode[0]) begin
                    kind = K_STORE;
                end else begin
                    kind = K_LOAD;
                    fn   = FN_PASS;
                end
            end
            default: begin
                kind = K_NOP;
            end
        endcase
    end
endmodule

// File: rtl/seq_ctrl_gen.sv
module seq_ctrl_gen
    import seq_pkg::*;
#(
    parameter int FN_W = 3
) (
    input  logic            rst,
    input  state_e          state,
    input  kind_e           kind,
    input  logic [FN_W-1:0] fn,
    input  logic            mem_ready,
    output ctrl_t           ctrl,
    output logic [FN_W-1:0] alu_fn
);
    always_comb begin
        ctrl   = '0;
        alu_fn = '0;
        if (!rst) begin
            case (state)
                S_F_ADDR: begin
                    ctrl.mar_load = 1'b1;
                    ctrl.mar_sel  = MAR_FROM_PC;
                end
                S_F_READ, S_OP_READ: begin
                    ctrl.mem_read = 1'b1;
                    ctrl.mdr_load = mem_ready;
                end
                S_F_IR: begin
                    ctrl.ir_load = 1'b1;
                    ctrl.pc_inc  = 1'b1;
                end
                S_EA: begin
                    ctrl.mar_load  = 1'b1;
                    ctrl.mar_sel   = MAR_FROM_ALU;
                    ctrl.alu_b_sel = 1'b1;
                end
                S_OP_ADDR: begin
                    ctrl.mar_load = 1'b1;
                    ctrl.mar_sel  = MAR_FROM_IR;
                end
                S_EXEC, S_WB: begin
                    alu_fn         = fn;
                    ctrl.alu_a_sel = (kind != K_ALU_REG);
                    if (state == S_EXEC) begin
                        ctrl.status_load = (kind != K_LOAD);
                    end else begin
                        ctrl.rd_load = 1'b1;
                    end
                end
                S_ST_DATA: begin
                    ctrl.mdr_load = 1'b1;
                    ctrl.mdr_sel  = 1'b1;
                end
                S_ST_WRITE: begin
                    ctrl.mem_write = 1'b1;
                end
                default: begin
                    ctrl = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int              OPC_W   = 4,
    parameter int              FN_W    = 3,
    parameter logic [FN_W-1:0] FN_PASS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir_opcode,
    input  logic             ir_mode,
    input  logic             mem_ready,
    output logic             mar_load,
    output logic [1:0]       mar_sel,
    output logic             mdr_load,
    output logic             mdr_sel,
    output logic             mem_read,
    output logic             mem_write,
    output logic             ir_load,
    output logic             pc_inc,
    output logic             alu_a_sel,
    output logic             alu_b_sel,
    output logic [FN_W-1:0]  alu_fn,
    output logic             status_load,
    output logic             rd_load
);
    typedef struct packed {
        state_e          state;
        kind_e           kind;
        logic [FN_W-1:0] fn;
    } seq_t;

    seq_t            seq_d, seq_q;
    kind_e           dec_kind;
    logic [FN_W-1:0] dec_fn;
    ctrl_t           ctrl;

    seq_decode #(.OPC_W(OPC_W), .FN_W(FN_W), .FN_PASS(FN_PASS)) u_decode (
        .opcode (ir_opcode),
        .kind   (dec_kind),
        .fn     (dec_fn)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            S_F_ADDR: seq_d.state = S_F_READ;
            S_F_READ: if (mem_ready) seq_d.state = S_F_IR;
            S_F_IR:   seq_d.state = S_DECODE;
            S_DECODE: begin
                seq_d.kind = dec_kind;
                seq_d.fn   = dec_fn;
                case (dec_kind)
                    K_ALU_REG: seq_d.state = S_EXEC;
                    K_NOP:     seq_d.state = S_F_ADDR;
                    default:   seq_d.state = ir_mode ? S_EA : S_OP_ADDR;
                endcase
            end
            S_EA, S_OP_ADDR:
                seq_d.state = (seq_q.kind == K_STORE) ? S_ST_DATA : S_OP_READ;
            S_OP_READ:  if (mem_ready) seq_d.state = S_EXEC;
            S_EXEC:     seq_d.state = S_WB;
            S_WB:       seq_d.state = S_F_ADDR;
            S_ST_DATA:  seq_d.state = S_ST_WRITE;
            S_ST_WRITE: if (mem_ready) seq_d.state = S_F_ADDR;
            default:    seq_d.state = S_F_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= S_F_ADDR;
            seq_q.kind  <= K_NOP;
            seq_q.fn    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    seq_ctrl_gen #(.FN_W(FN_W)) u_ctrl (
        .rst       (rst),
        .state     (seq_q.state),
        .kind      (seq_q.kind),
        .fn        (seq_q.fn),
        .mem_ready (mem_ready),
        .ctrl      (ctrl),
        .alu_fn    (alu_fn)
    );

    assign mar_load    = ctrl.mar_load;
    assign mar_sel     = ctrl.mar_sel;
    assign mdr_load    = ctrl.mdr_load;
    assign mdr_sel     = ctrl.mdr_sel;
    assign mem_read    = ctrl.mem_read;
    assign mem_write   = ctrl.mem_write;
    assign ir_load     = ctrl.ir_load;
    assign pc_inc      = ctrl.pc_inc;
    assign alu_a_sel   = ctrl.alu_a_sel;
    assign alu_b_sel   = ctrl.alu_b_sel;
    assign status_load = ctrl.status_load;
    assign rd_load     = ctrl.rd_load;

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $countones({mar_load, mdr_load, ir_load, status_load, rd_load}) <= 1); // R11
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write)); // R11
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_read && !mem_ready) |=> mem_read); // R12
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_write && !mem_ready) |=> mem_write); // R12
    AST_IR_AFTER_MDR: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> $past(mdr_load)); // R2
    AST_WB_KEEPS_FN: assert property (@(posedge clk) disable iff (rst)
        rd_load |-> $stable(alu_fn)); // R7
endmodule

// File: tb/seq_core_tb.sv
module seq_core_tb;
    localparam int OPC_W = 4;
    localparam int FN_W  = 3;
    localparam logic [FN_W-1:0] FN_PASS = 3'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [OPC_W-1:0] opc;
    logic             mode, rdy;
    logic             mar_load, mdr_load, mdr_sel, mem_read, mem_write;
    logic             ir_load, pc_inc, alu_a_sel, alu_b_sel, status_load, rd_load;
    logic [1:0]       mar_sel;
    logic [FN_W-1:0]  alu_fn;

    seq_core #(.OPC_W(OPC_W), .FN_W(FN_W), .FN_PASS(FN_PASS)) u_dut (
        .clk(clk), .rst(rst), .ir_opcode(opc), .ir_mode(mode), .mem_ready(rdy),
        .mar_load(mar_load), .mar_sel(mar_sel), .mdr_load(mdr_load), .mdr_sel(mdr_sel),
        .mem_read(mem_read), .mem_write(mem_write), .ir_load(ir_load), .pc_inc(pc_inc),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_fn(alu_fn),
        .status_load(status_load), .rd_load(rd_load)
    );

    logic [15:0] act;
    assign act = {mar_load, mar_sel, mdr_load, mdr_sel, mem_read, mem_write,
                  ir_load, pc_inc, alu_a_sel, alu_b_sel, alu_fn, status_load, rd_load};

    logic [15:0]      exp_q[$];
    logic [OPC_W-1:0] opc_q[$];
    logic             mode_q[$];
    logic             rdy_q[$];
    string            tag_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    event go;

    function automatic logic [15:0] mk(logic ma, logic [1:0] ms, logic md, logic mds,
                                       logic rd, logic wr, logic ir, logic pc,
                                       logic a, logic b, logic [FN_W-1:0] fn,
                                       logic st, logic rl);
        return {ma, ms, md, mds, rd, wr, ir, pc, a, b, fn, st, rl};
    endfunction

    task automatic chk(string tag, logic [15:0] a, logic [15:0] e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic push(string tag, logic [OPC_W-1:0] o, logic m, logic r, logic [15:0] e);
        tag_q.push_back(tag);
        opc_q.push_back(o);
        mode_q.push_back(m);
        rdy_q.push_back(r);
        exp_q.push_back(e);
    endtask

    // wait cycles with the strobe held, then the ready cycle
    task automatic mem_phase(string tag, logic [OPC_W-1:0] o, logic m, int waits, logic wr);
        for (int i = 0; i < waits; i++)
            push(tag, o, m, 1'b0, mk(0, 0, 0, 0, !wr, wr, 0, 0, 0, 0, 0, 0, 0));
        push(tag, o, m, 1'b1, mk(0, 0, !wr, 0, !wr, wr, 0, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic instr(string tag, logic [OPC_W-1:0] o, logic m, int fw, int ow);
        logic [FN_W-1:0] fn;
        logic            is_mem;
        push({tag, " R2 fetch addr"}, o, m, 1'b0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        mem_phase({tag, " R2 R12 fetch read"}, o, m, fw, 1'b0);
        push({tag, " R2 ir load"}, o, m, 1'b0, mk(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        push({tag, " R2 decode"}, o, m, 1'b0, '0);
        if (o[3:2] == 2'b11) return; // R10 back to fetch
        is_mem = (o[3:2] != 2'b00);
        if (is_mem) begin
            if (m) push({tag, " R5 ea"}, o, m, 1'b0, mk(1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
            else   push({tag, " R4 addr"}, o, m, 1'b0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        end
        if (o[3:2] == 2'b10 && o[0]) begin
            push({tag, " R9 store data"}, o, m, 1'b0, mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            mem_phase({tag, " R9 R12 store write"}, o, m, ow, 1'b1);
            return;
        end
        if (is_mem) mem_phase({tag, " R12 operand read"}, o, m, ow, 1'b0);
        if (o[3:2] == 2'b10) begin
            push({tag, " R8 exec"}, o, m, 1'b0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, FN_PASS, 0, 0));
            push({tag, " R8 R7 wb"}, o, m, 1'b0, mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, FN_PASS, 0, 1));
        end else begin
            fn = {1'b0, o[1:0]};
            push({tag, " R6 R3 exec"}, o, m, 1'b0, mk(0, 0, 0, 0, 0, 0, 0, 0, is_mem, 0, fn, 1, 0));
            push({tag, " R7 wb"}, o, m, 1'b0, mk(0, 0, 0, 0, 0, 0, 0, 0, is_mem, 0, fn, 0, 1));
        end
    endtask

    // driver
    initial begin
        opc = '0; mode = 1'b0; rdy = 1'b0;
        instr("add reg",         4'b0000, 1'b0, 0, 0);
        instr("or reg",          4'b0011, 1'b0, 2, 0);
        instr("sub mem direct",  4'b0101, 1'b0, 1, 3);
        instr("and mem base",    4'b0110, 1'b1, 0, 0);
        instr("load direct",     4'b1000, 1'b0, 0, 2);
        instr("load base",       4'b1000, 1'b1, 1, 0);
        instr("store direct",    4'b1001, 1'b0, 0, 2);
        instr("store base",      4'b1001, 1'b1, 0, 0);
        instr("nop R10",         4'b1100, 1'b0, 0, 0);
        instr("sub reg mode1 R3", 4'b0001, 1'b1, 0, 0);
        push("R1 R2 next fetch", 4'b0000, 1'b0, 1'b0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        tag_q[0] = "R1 first cycle after reset";
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R1 reset quiet", act, '0);
        end
        @(negedge clk);
        rst = 1'b0;
        ->go;
    end

    // monitor
    initial begin
        @go;
        while (exp_q.size() > 0) begin
            string            t;
            logic [15:0]      e;
            t    = tag_q.pop_front();
            e    = exp_q.pop_front();
            opc  = opc_q.pop_front();
            mode = mode_q.pop_front();
            rdy  = rdy_q.pop_front();
            #1;
            chk(t, act, e);
            @(negedge clk);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule